// File: doc/BRIEF.md
# Deep Low-Power Entry and Wakeup Sequencer

This block decides whether a small processor system may drop into one of its deep low-power states, and brings it back out again. The core gives it three entry strobes: wait-for-interrupt, wait-for-event and return-from-handler. It also gives it the deep-sleep and sleep-on-exit enables and the pending interrupt and event indications. The system supplies a 3-bit mode selector, the wakeup status flags, the real-time-clock event flags with their enable mask, wakeup pin edges, an external reset request and a periodic auto-wakeup tick.

Entry happens only when every qualifying condition holds in the same cycle. Once the system is asleep, the block watches the wakeup sources that suit the current state. Exit from the two stop variants and from standby goes straight back to RUN. Exit from shutdown first drives a domain reset that lasts several cycles and behaves like a power-on reset. A small cause register records which sources ended the sleep. It belongs to the always-on domain, so the domain reset does not clear it.

Top module: `lpm_gate`

## Requirements
- R1: After the asynchronous reset, the power state is RUN (code 0), the domain reset is low and the wakeup cause is 0.
- R2: In RUN, entry needs the deep-sleep enable together with a wait-for-interrupt strobe and no pending interrupt, or a wait-for-event strobe and no pending event. Without one of these, the state stays RUN.
- R3: A return-from-handler strobe causes entry only when deep-sleep is set, sleep-on-exit is set and no interrupt is pending.
- R4: The mode selector picks the target state. 000 gives stop-0 (state code 1), 001 gives stop-1 (code 2), 011 gives standby (code 3), and any value with bit 2 set gives shutdown (code 4). The value 010 leaves the state at RUN.
- R5: Entry is blocked while any wakeup status flag is set. It is also blocked while any real-time-clock flag whose enable bit is set is high. A real-time-clock flag whose enable bit is clear does not block entry.
- R6: If a wakeup pin edge, the auto-wakeup tick or the external reset is active in the same cycle as an otherwise valid entry request, the entry is abandoned and the state stays RUN.
- R7: In stop-0, stop-1 or standby, a wakeup pin edge, the auto-wakeup tick or the external reset returns the state to RUN at the next edge, without a domain reset.
- R8: In stop-0 or stop-1, an enabled real-time-clock flag wakes the system only when the rising-edge arm input is set and the OR of the enabled flags goes from 0 to 1. With the arm clear, or with a flag that stays high, the system stays asleep.
- R9: In standby and shutdown, any enabled real-time-clock flag that is high wakes the system, whatever the value of the arm input.
- R10: Any wake from shutdown puts the state into the reset phase (code 5). The domain reset is then high for exactly 4 cycles, after which the state is RUN. Wakeup sources and entry requests have no effect during the reset phase.
- R11: On every exit, the cause register loads the active sources in this encoding: bit 0 wakeup pin, bit 1 real-time clock, bit 2 auto-wakeup tick, bit 3 external reset. It keeps that value through the domain reset and until the next exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| hret_i | input | 1 | Return-from-handler strobe |
| deep_en_i | input | 1 | Deep-sleep enable |
| exit_sleep_en_i | input | 1 | Sleep-on-exit enable |
| irq_pend_i | input | 1 | An interrupt is pending |
| evt_pend_i | input | 1 | An event is pending |
| mode_sel_i | input | 3 | Low-power mode selector |
| wuf_i | input | NPIN | Wakeup status flags |
| rtc_flag_i | input | NRTC | Real-time-clock event flags |
| rtc_src_en_i | input | NRTC | Enable mask for real-time-clock flags as wakeup sources |
| rtc_rise_arm_i | input | 1 | Rising-edge sensitivity armed on the clock-event line |
| wake_pin_i | input | NPIN | Wakeup pin edge pulses |
| ext_rst_i | input | 1 | External reset request |
| awu_tick_i | input | 1 | Periodic auto-wakeup tick |
| pwr_state_o | output | 3 | Current power state code |
| dom_rst_o | output | 1 | Domain reset, active high |
| wake_cause_o | output | 4 | Recorded wakeup cause |

## Verification
The assertions assume that the strobes, pin edges, the tick and the external reset request are all synchronous to the clock and change only between edges. They also assume that the flag and enable inputs do not change during the edge at which a decision is made. The assertion on stop-mode clock wakeup assumes the arm input is the only thing gating that source. The bench changes every input on the falling edge and holds it for at least a full cycle. It also clears each single-cycle source before it moves to the next case, so every decision it checks depends on one known set of inputs.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_STOP0 = 3'd1,
    PS_STOP1 = 3'd2,
    PS_STBY  = 3'd3,
    PS_SHDN  = 3'd4,
    PS_RSTP  = 3'd5
  } pstate_t;

  localparam int unsigned NCAUSE    = 4;
  localparam int unsigned CAUSE_PIN = 0;
  localparam int unsigned CAUSE_RTC = 1;
  localparam int unsigned CAUSE_AWU = 2;
  localparam int unsigned CAUSE_EXT = 3;

  // Maps the selector to a target state; PS_RUN means no deep entry.
  function automatic pstate_t decode_mode(input logic [2:0] sel);
    if (sel[2])              return PS_SHDN;
    else if (sel == 3'b000)  return PS_STOP0;
    else if (sel == 3'b001)  return PS_STOP1;
    else if (sel == 3'b011)  return PS_STBY;
    else                     return PS_RUN;
  endfunction

endpackage

// File: rtl/lpm_entry_qual.sv
module lpm_entry_qual
  import lpm_pkg::*;
#(
  parameter int unsigned NPIN = 2,
  parameter int unsigned NRTC = 5
) (
  input  logic            wfi_i,
  input  logic            wfe_i,
  input  logic            hret_i,
  input  logic            deep_en_i,
  input  logic            exit_sleep_en_i,
  input  logic            irq_pend_i,
  input  logic            evt_pend_i,
  input  logic [2:0]      mode_sel_i,
  input  logic [NPIN-1:0] wuf_i,
  input  logic [NRTC-1:0] rtc_flag_i,
  input  logic [NRTC-1:0] rtc_src_en_i,
  input  logic            abandon_i,
  output logic            go_o,
  output pstate_t         tgt_o
);

  logic strobe_ok;
  logic flags_clear;

  always_comb begin
    tgt_o       = decode_mode(mode_sel_i);
    strobe_ok   = (wfi_i & ~irq_pend_i) |
                  (wfe_i & ~evt_pend_i) |
                  (hret_i & exit_sleep_en_i & ~irq_pend_i);
    flags_clear = ~(|wuf_i) & ~(|(rtc_flag_i & rtc_src_en_i));
    go_o        = deep_en_i & strobe_ok & flags_clear &
                  (tgt_o != PS_RUN) & ~abandon_i;
  end

endmodule

// File: rtl/lpm_wake_det.sv
module lpm_wake_det
  import lpm_pkg::*;
#(
  parameter int unsigned NPIN = 2,
  parameter int unsigned NRTC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pstate_t           st_i,
  input  logic [NPIN-1:0]   wake_pin_i,
  input  logic              ext_rst_i,
  input  logic              awu_tick_i,
  input  logic [NRTC-1:0]   rtc_flag_i,
  input  logic [NRTC-1:0]   rtc_src_en_i,
  input  logic              rtc_rise_arm_i,
  output logic              abandon_o,
  output logic              wake_o,
  output logic [NCAUSE-1:0] cause_o
);

  logic rtc_hit;
  logic rtc_hit_q;
  logic rtc_src;
  logic in_stop;
  logic in_lp;

  always_comb begin
    rtc_hit   = |(rtc_flag_i & rtc_src_en_i);
    in_stop   = (st_i == PS_STOP0) || (st_i == PS_STOP1);
    in_lp     = in_stop || (st_i == PS_STBY) || (st_i == PS_SHDN);
    rtc_src   = in_stop ? (rtc_rise_arm_i & rtc_hit & ~rtc_hit_q) : rtc_hit;
    cause_o   = '0;
    cause_o[CAUSE_PIN] = |wake_pin_i;
    cause_o[CAUSE_RTC] = rtc_src;
    cause_o[CAUSE_AWU] = awu_tick_i;
    cause_o[CAUSE_EXT] = ext_rst_i;
    abandon_o = (|wake_pin_i) | awu_tick_i | ext_rst_i;
    wake_o    = in_lp & (|cause_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rtc_hit_q <= 1'b0;
    else        rtc_hit_q <= rtc_hit;
  end

endmodule

// File: rtl/lpm_rst_seq.sv
module lpm_rst_seq #(
  parameter int unsigned RST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(RST_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start_i | busy_o;
    cnt_d  = cnt_q;
    busy_d = busy_o;
    if (start_i) begin
      cnt_d  = CNT_TOP;
      busy_d = 1'b1;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
    done_o = busy_o & (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_o <= busy_d;
    end
  end

endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
  import lpm_pkg::*;
#(
  parameter int unsigned NPIN    = 2,
  parameter int unsigned NRTC    = 5,
  parameter int unsigned RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wfi_i,
  input  logic              wfe_i,
  input  logic              hret_i,
  input  logic              deep_en_i,
  input  logic              exit_sleep_en_i,
  input  logic              irq_pend_i,
  input  logic              evt_pend_i,
  input  logic [2:0]        mode_sel_i,
  input  logic [NPIN-1:0]   wuf_i,
  input  logic [NRTC-1:0]   rtc_flag_i,
  input  logic [NRTC-1:0]   rtc_src_en_i,
  input  logic              rtc_rise_arm_i,
  input  logic [NPIN-1:0]   wake_pin_i,
  input  logic              ext_rst_i,
  input  logic              awu_tick_i,
  output logic [2:0]        pwr_state_o,
  output logic              dom_rst_o,
  output logic [NCAUSE-1:0] wake_cause_o
);

  pstate_t           st_q, st_d;
  logic              go;
  pstate_t           tgt;
  logic              abandon;
  logic              wake;
  logic [NCAUSE-1:0] cause_now;
  logic              rst_start;
  logic              rst_done;
  logic              cause_en;

  lpm_entry_qual #(.NPIN(NPIN), .NRTC(NRTC)) u_qual (
    .wfi_i(wfi_i), .wfe_i(wfe_i), .hret_i(hret_i),
    .deep_en_i(deep_en_i), .exit_sleep_en_i(exit_sleep_en_i),
    .irq_pend_i(irq_pend_i), .evt_pend_i(evt_pend_i),
    .mode_sel_i(mode_sel_i), .wuf_i(wuf_i),
    .rtc_flag_i(rtc_flag_i), .rtc_src_en_i(rtc_src_en_i),
    .abandon_i(abandon), .go_o(go), .tgt_o(tgt)
  );

  lpm_wake_det #(.NPIN(NPIN), .NRTC(NRTC)) u_wake (
    .clk(clk), .rst_n(rst_n), .st_i(st_q),
    .wake_pin_i(wake_pin_i), .ext_rst_i(ext_rst_i), .awu_tick_i(awu_tick_i),
    .rtc_flag_i(rtc_flag_i), .rtc_src_en_i(rtc_src_en_i),
    .rtc_rise_arm_i(rtc_rise_arm_i),
    .abandon_o(abandon), .wake_o(wake), .cause_o(cause_now)
  );

  lpm_rst_seq #(.RST_CYC(RST_CYC)) u_rseq (
    .clk(clk), .rst_n(rst_n), .start_i(rst_start),
    .busy_o(dom_rst_o), .done_o(rst_done)
  );

  always_comb begin
    st_d      = st_q;
    rst_start = 1'b0;
    case (st_q)
      PS_RUN:                     if (go)   st_d = tgt;
      PS_STOP0, PS_STOP1, PS_STBY: if (wake) st_d = PS_RUN;
      PS_SHDN: if (wake) begin
        st_d      = PS_RSTP;
        rst_start = 1'b1;
      end
      PS_RSTP:                    if (rst_done) st_d = PS_RUN;
      default:                    st_d = PS_RUN;
    endcase
    cause_en = wake;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_RUN;
    else        st_q <= st_d;
  end

  // Always-on cause register: only the power-on reset clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wake_cause_o <= '0;
    else if (cause_en) wake_cause_o <= cause_now;
  end

  assign pwr_state_o = st_q;

  // R2
  no_deep_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && !deep_en_i) |=> st_q == PS_RUN);

  // R5
  wuf_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_RUN && |wuf_i) |=> st_q == PS_RUN);

  // R8
  stop_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PS_STOP0 || st_q == PS_STOP1) && !rtc_rise_arm_i &&
     !(|wake_pin_i) && !awu_tick_i && !ext_rst_i) |=> st_q == $past(st_q));

  // R10
  shdn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SHDN && wake) |=> (st_q == PS_RSTP && dom_rst_o));

  // R10
  rst_phase_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dom_rst_o == (st_q == PS_RSTP));

  // R11
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake |=> $stable(wake_cause_o));

endmodule

// File: tb/lpm_gate_test.sv
`timescale 1ns/1ps
module lpm_gate_test;

  localparam int NPIN = 2;
  localparam int NRTC = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic wfi, wfe, hret, deep, exit_en, irq, evt;
  logic [2:0] mode;
  logic [NPIN-1:0] wuf, pin;
  logic [NRTC-1:0] rflag, ren;
  logic arm, ext, awu;
  logic [2:0] st;
  logic drst;
  logic [3:0] cause;

  always #4 clk = ~clk;  // 125 MHz

  lpm_gate #(.NPIN(NPIN), .NRTC(NRTC), .RST_CYC(4)) uut (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .hret_i(hret),
    .deep_en_i(deep), .exit_sleep_en_i(exit_en), .irq_pend_i(irq),
    .evt_pend_i(evt), .mode_sel_i(mode), .wuf_i(wuf), .rtc_flag_i(rflag),
    .rtc_src_en_i(ren), .rtc_rise_arm_i(arm), .wake_pin_i(pin),
    .ext_rst_i(ext), .awu_tick_i(awu), .pwr_state_o(st),
    .dom_rst_o(drst), .wake_cause_o(cause)
  );

  typedef struct {
    logic [2:0] st;
    logic       rs;
    logic [3:0] ca;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [2:0] RUN = 3'd0, S0 = 3'd1, S1 = 3'd2, SB = 3'd3,
                         SD = 3'd4, RP = 3'd5;

  // Monitor: compare registered outputs at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (st !== e.st || drst !== e.rs || cause !== e.ca) begin
        errors++;
        $display("FAIL %s actual st=%0d rst=%0b cause=%h expected st=%0d rst=%0b cause=%h",
                 e.tag, st, drst, cause, e.st, e.rs, e.ca);
      end
    end
  end

  // Driver: inputs are already set at a falling edge; push the expectation after the rising edge.
  task automatic step(input logic [2:0] es, input logic er, input logic [3:0] ec,
                      input string tag);
    @(posedge clk);
    #1;
    sb.push_back('{st: es, rs: er, ca: ec, tag: tag});
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; wfi = 0; wfe = 0; hret = 0; deep = 0; exit_en = 0;
    irq = 0; evt = 0; mode = 3'b000; wuf = '0; pin = '0; rflag = '0;
    ren = '0; arm = 0; ext = 0; awu = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(RUN, 0, 4'h0, "R1 reset state");

    // R2
    wfi = 1; step(RUN, 0, 4'h0, "R2 no deep-sleep enable");
    deep = 1; irq = 1; step(RUN, 0, 4'h0, "R2 wfi with pending irq");
    wfi = 0; wfe = 1; evt = 1; step(RUN, 0, 4'h0, "R2 wfe with pending event");
    evt = 0; step(S0, 0, 4'h0, "R2 R4 wfe entry to stop0");
    wfe = 0; irq = 0; step(S0, 0, 4'h0, "R7 stop0 holds");
    pin = 2'b01; step(RUN, 0, 4'h1, "R7 R11 pin wake stop0");
    pin = '0;

    // R3
    mode = 3'b001; hret = 1; step(RUN, 0, 4'h1, "R3 no sleep-on-exit");
    exit_en = 1; irq = 1; step(RUN, 0, 4'h1, "R3 pending irq");
    irq = 0; step(S1, 0, 4'h1, "R3 R4 return entry to stop1");
    hret = 0; awu = 1; step(RUN, 0, 4'h4, "R7 R11 tick wake stop1");
    awu = 0;

    // R4 / R5 / R9
    mode = 3'b010; wfi = 1; step(RUN, 0, 4'h4, "R4 selector 010 no entry");
    mode = 3'b011; wuf = 2'b01; step(RUN, 0, 4'h4, "R5 wakeup flag blocks");
    wuf = '0; ren = 5'b00001; rflag = 5'b00001;
    step(RUN, 0, 4'h4, "R5 enabled clock flag blocks");
    rflag = 5'b00010; step(SB, 0, 4'h4, "R4 R5 disabled flag ignored, standby");
    wfi = 0; step(SB, 0, 4'h4, "R9 standby holds");
    rflag = 5'b00011; step(RUN, 0, 4'h2, "R9 clock wake standby unarmed");
    rflag = '0;

    // R6
    mode = 3'b000; wfi = 1; pin = 2'b10;
    step(RUN, 0, 4'h2, "R6 pin edge abandons entry");
    pin = '0; ext = 1; step(RUN, 0, 4'h2, "R6 ext reset abandons entry");
    ext = 0; step(S0, 0, 4'h2, "R4 stop0 entry");
    wfi = 0; ext = 1; step(RUN, 0, 4'h8, "R7 R11 ext reset wake stop0");
    ext = 0;

    // R8
    wfi = 1; step(S0, 0, 4'h8, "R8 re-enter stop0");
    wfi = 0; rflag = 5'b00001; step(S0, 0, 4'h8, "R8 unarmed flag rise");
    step(S0, 0, 4'h8, "R8 unarmed flag held");
    arm = 1; step(S0, 0, 4'h8, "R8 armed but no edge");
    rflag = '0; step(S0, 0, 4'h8, "R8 flag falls");
    rflag = 5'b00001; step(RUN, 0, 4'h2, "R8 armed rising edge wakes");
    rflag = '0; arm = 0;

    // R10 / R9 / R11
    mode = 3'b100; wfi = 1; step(SD, 0, 4'h2, "R4 shutdown entry 100");
    wfi = 0; step(SD, 0, 4'h2, "R10 shutdown holds");
    rflag = 5'b00001; step(RP, 1, 4'h2, "R9 R10 clock wake shutdown");
    rflag = '0; pin = 2'b01; awu = 1;
    step(RP, 1, 4'h2, "R10 reset phase ignores sources");
    pin = '0; awu = 0;
    step(RP, 1, 4'h2, "R10 reset phase cycle 3");
    step(RP, 1, 4'h2, "R10 reset phase cycle 4");
    step(RUN, 0, 4'h2, "R10 R11 back to run, cause kept");

    mode = 3'b111; wfe = 1; step(SD, 0, 4'h2, "R4 shutdown entry 111");
    wfe = 0; ext = 1; pin = 2'b01; step(RP, 1, 4'h9, "R11 ext and pin wake");
    ext = 0; pin = '0;
    repeat (3) step(RP, 1, 4'h9, "R10 reset phase");
    step(RUN, 0, 4'h9, "R10 R11 run after reset");

    @(negedge clk);
    finish_run();
  end

endmodule